// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block divides the oscillator clock of a small microcontroller core into instruction cycles and marks each cycle with single-clock strobes. One fetch strobe opens every cycle. One execute strobe closes every normal cycle. A timer enable pulses once per cycle, so the timer's internal count rate follows the chosen cycle length. A static option input, captured only while reset is held, sets the cycle length to two or four oscillator periods.

The instruction decoder reports flow-disturbing events through three inputs: a write to the program counter, a jump-class instruction (jump, call or any return), and a conditional skip whose test came out true. An event seen in the execute period of a normal cycle turns the next instruction cycle into an extra cycle. In that cycle the fetched word is thrown away: the flush output stays high for the whole cycle and no execute strobe appears. Jump-class events stretch only in the four-period mode. Program counter writes and true skips stretch in both modes.

Top module: `icts_top`

## Requirements
- R1: On a clock edge with `rst` high the block enters phase 0 of a normal cycle. In the cycle that follows, `fetch_stb`=1, `exec_stb`=0, `flush`=0 and `tmr_en`=1.
- R2: With `opt_long`=0 captured at reset, each cycle lasts 2 clocks: `fetch_stb` in the first, `exec_stb` in the second.
- R3: With `opt_long`=1 captured at reset, each cycle lasts 4 clocks: `fetch_stb` in the first, `exec_stb` in the fourth, neither in the middle two.
- R4: `pc_write_ev` high in a clock where `exec_stb` is high makes the next instruction cycle an extra cycle. That cycle has the normal length, shows `fetch_stb` in its first clock, holds `flush` high in every clock and shows no `exec_stb`. A normal cycle follows.
- R5: `jump_ev` creates an extra cycle in the four-period mode. In the two-period mode it has no effect: the next execute strobe comes 2 clocks later and `flush` stays low.
- R6: `skip_true_ev` creates an extra cycle in both modes.
- R7: Event inputs are sampled only in clocks where `exec_stb` is high. Events in any other clock, including every clock of an extra cycle, have no effect.
- R8: `tmr_en` pulses once per instruction cycle, extra cycles included, in the cycle's first clock. This gives a rate of clock/2 or clock/4.
- R9: Changing `opt_long` while `rst` is low does not change the cycle length.
- R10: Two stretched instructions in a row each get their own extra cycle. The gap between their execute strobes is twice the cycle length both times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| opt_long | input | 1 | Cycle length option: 0 gives two periods, 1 gives four; captured during reset |
| pc_write_ev | input | 1 | Decoder: current instruction writes the program counter |
| jump_ev | input | 1 | Decoder: current instruction is a jump, call or return |
| skip_true_ev | input | 1 | Decoder: conditional skip whose test is true |
| fetch_stb | output | 1 | High in the first clock of each instruction cycle |
| exec_stb | output | 1 | High in the last clock of each normal instruction cycle |
| flush | output | 1 | High through every clock of an extra cycle |
| tmr_en | output | 1 | Timer clock enable, one pulse per instruction cycle |

## Verification
The hardest condition to reach from the ports is an event input held high through the last clock of an extra cycle. A design that samples events there would chain extra cycles without end. The bench reaches it by holding the program-counter-write input high without a break across two whole instructions. It then checks that each execute-to-execute gap is exactly twice the cycle length. The mode-gated jump case needs a reset into each mode. A table walk covers every event type in both modes.

// File: rtl/icts_pkg.sv
package icts_pkg;
  typedef enum logic {MODE_SHORT = 1'b0, MODE_LONG = 1'b1} cyc_mode_e;
endpackage

// File: rtl/icts_mode_latch.sv
module icts_mode_latch
  import icts_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      opt_long,
  output cyc_mode_e mode_q
);
  always_ff @(posedge clk) begin
    if (rst) mode_q <= opt_long ? MODE_LONG : MODE_SHORT;
  end

  p_mode_static_r9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(mode_q));
endmodule

// File: rtl/icts_phase_ctr.sv
module icts_phase_ctr
  import icts_pkg::*;
#(
  parameter int SHORT_LEN = 2,
  parameter int LONG_LEN  = 4,
  localparam int PH_W     = (LONG_LEN > 2) ? $clog2(LONG_LEN) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  cyc_mode_e       mode_q,
  output logic [PH_W-1:0] ph_q,
  output logic [PH_W-1:0] ph_nxt,
  output logic            at_last
);
  localparam logic [PH_W-1:0] LAST_S = PH_W'(SHORT_LEN - 1);
  localparam logic [PH_W-1:0] LAST_L = PH_W'(LONG_LEN - 1);

  logic [PH_W-1:0] last_ph;

  always_comb begin
    last_ph = (mode_q == MODE_LONG) ? LAST_L : LAST_S;
    at_last = (ph_q == last_ph);
    ph_nxt  = at_last ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_nxt;
  end

  p_phase_range_r3: assert property (@(posedge clk) disable iff (rst)
    ph_q <= last_ph);
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    at_last |=> ph_q == '0);
endmodule

// File: rtl/icts_stretch_ctl.sv
module icts_stretch_ctl
  import icts_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cyc_mode_e mode_q,
  input  logic      at_last,
  input  logic      pc_write_ev,
  input  logic      jump_ev,
  input  logic      skip_true_ev,
  output logic      extra_q,
  output logic      extra_nxt
);
  logic stretch;

  always_comb begin
    stretch   = pc_write_ev | skip_true_ev | ((mode_q == MODE_LONG) & jump_ev);
    extra_nxt = at_last ? (~extra_q & stretch) : extra_q;
  end

  always_ff @(posedge clk) begin
    if (rst) extra_q <= 1'b0;
    else     extra_q <= extra_nxt;
  end

  p_extra_single_r7: assert property (@(posedge clk) disable iff (rst)
    (extra_q && at_last) |=> !extra_q);
  p_jump_short_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SHORT && at_last && !extra_q && !pc_write_ev && !skip_true_ev)
      |=> !extra_q);
  p_pc_write_stretches_r4: assert property (@(posedge clk) disable iff (rst)
    (at_last && !extra_q && pc_write_ev) |=> extra_q);
endmodule

// File: rtl/icts_strobe_reg.sv
module icts_strobe_reg #(
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] ph_nxt,
  input  logic            last_nxt,
  input  logic            extra_nxt,
  output logic            fetch_stb,
  output logic            exec_stb,
  output logic            flush,
  output logic            tmr_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_stb <= 1'b1;
      exec_stb  <= 1'b0;
      flush     <= 1'b0;
      tmr_en    <= 1'b1;
    end else begin
      fetch_stb <= (ph_nxt == '0);
      exec_stb  <= last_nxt & ~extra_nxt;
      flush     <= extra_nxt;
      tmr_en    <= (ph_nxt == '0);
    end
  end

  p_no_exec_in_flush_r4: assert property (@(posedge clk) disable iff (rst)
    flush |-> !exec_stb);
  p_exec_then_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    exec_stb |=> fetch_stb);
  p_tmr_single_r8: assert property (@(posedge clk) disable iff (rst)
    tmr_en |=> !tmr_en);
  p_fetch_exec_apart_r3: assert property (@(posedge clk) disable iff (rst)
    !(fetch_stb && exec_stb));
endmodule

// File: rtl/icts_top.sv
module icts_top
  import icts_pkg::*;
#(
  parameter int SHORT_LEN = 2,
  parameter int LONG_LEN  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic opt_long,
  input  logic pc_write_ev,
  input  logic jump_ev,
  input  logic skip_true_ev,
  output logic fetch_stb,
  output logic exec_stb,
  output logic flush,
  output logic tmr_en
);
  localparam int PH_W = (LONG_LEN > 2) ? $clog2(LONG_LEN) : 1;
  localparam logic [PH_W-1:0] LAST_S = PH_W'(SHORT_LEN - 1);
  localparam logic [PH_W-1:0] LAST_L = PH_W'(LONG_LEN - 1);

  cyc_mode_e       mode_q;
  logic [PH_W-1:0] ph_q, ph_nxt;
  logic            at_last, extra_q, extra_nxt, last_nxt;

  icts_mode_latch u_mode (
    .clk(clk), .rst(rst), .opt_long(opt_long), .mode_q(mode_q)
  );

  icts_phase_ctr #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_phase (
    .clk(clk), .rst(rst), .mode_q(mode_q),
    .ph_q(ph_q), .ph_nxt(ph_nxt), .at_last(at_last)
  );

  icts_stretch_ctl u_stretch (
    .clk(clk), .rst(rst), .mode_q(mode_q), .at_last(at_last),
    .pc_write_ev(pc_write_ev), .jump_ev(jump_ev), .skip_true_ev(skip_true_ev),
    .extra_q(extra_q), .extra_nxt(extra_nxt)
  );

  assign last_nxt = (ph_nxt == ((mode_q == MODE_LONG) ? LAST_L : LAST_S));

  icts_strobe_reg #(.PH_W(PH_W)) u_strobe (
    .clk(clk), .rst(rst), .ph_nxt(ph_nxt), .last_nxt(last_nxt),
    .extra_nxt(extra_nxt), .fetch_stb(fetch_stb), .exec_stb(exec_stb),
    .flush(flush), .tmr_en(tmr_en)
  );

  p_fetch_follows_exec_or_flush_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(flush) |-> $past(exec_stb));
endmodule

// File: tb/icts_top_bench.sv
module icts_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic opt_long = 1'b0;
  logic pc_write_ev = 1'b0, jump_ev = 1'b0, skip_true_ev = 1'b0;
  logic fetch_stb, exec_stb, flush, tmr_en;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  icts_top u_icts_top (
    .clk(clk), .rst(rst), .opt_long(opt_long),
    .pc_write_ev(pc_write_ev), .jump_ev(jump_ev), .skip_true_ev(skip_true_ev),
    .fetch_stb(fetch_stb), .exec_stb(exec_stb), .flush(flush), .tmr_en(tmr_en)
  );

  // Row fields: {mode, pc_write, jump, skip_true, expected_extra}
  localparam logic [4:0] VEC [0:7] = '{
    5'b0_000_0, 5'b0_100_1, 5'b0_010_0, 5'b0_001_1,
    5'b1_000_0, 5'b1_100_1, 5'b1_010_1, 5'b1_001_1
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1; opt_long = mode;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 fetch_stb after reset", fetch_stb, 1);
    chk("R1 exec_stb after reset", exec_stb, 0);
    chk("R1 flush after reset", flush, 0);
    chk("R1 tmr_en after reset", tmr_en, 1);
  endtask

  // Waits for an execute strobe, applies events in that clock (held if hold=1),
  // then counts clocks up to the next execute strobe.
  task automatic run_instr(input logic pc, input logic jp, input logic sk, input logic hold,
                           output int gap, output int nflush, output int nfetch, output int ntmr);
    int guard = 0;
    while (!exec_stb && guard < 50) begin
      @(negedge clk); guard++;
    end
    pc_write_ev = pc; jump_ev = jp; skip_true_ev = sk;
    gap = 0; nflush = 0; nfetch = 0; ntmr = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!hold) begin
        pc_write_ev = 1'b0; jump_ev = 1'b0; skip_true_ev = 1'b0;
      end
      gap++;
      nflush += int'(flush);
      nfetch += int'(fetch_stb);
      ntmr   += int'(tmr_en);
      if (exec_stb) break;
    end
  endtask

  initial begin
    while (cyc < 100000) begin
      @(posedge clk); cyc++;
    end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int gap, nf, nfe, nt, len, x;
    string tag;
    // Table walk: R2, R3, R4, R5, R6, R8
    for (int r = 0; r < 8; r++) begin
      do_reset(VEC[r][4]);
      len = VEC[r][4] ? 4 : 2;
      x = int'(VEC[r][0]);
      if (VEC[r][3])      tag = "R4 pc write";
      else if (VEC[r][2]) tag = "R5 jump";
      else if (VEC[r][1]) tag = "R6 skip true";
      else                tag = VEC[r][4] ? "R3 long cycle" : "R2 short cycle";
      run_instr(VEC[r][3], VEC[r][2], VEC[r][1], 1'b0, gap, nf, nfe, nt);
      chk({tag, " exec gap"}, gap, len * (1 + x));
      chk({tag, " flush clocks"}, nf, len * x);
      chk({tag, " fetch count"}, nfe, 1 + x);
      chk({"R8 tmr_en pulses, ", tag}, nt, 1 + x);
    end

    // R7: event away from the execute clock is ignored (long mode)
    do_reset(1'b1);
    run_instr(1'b0, 1'b0, 1'b0, 1'b0, gap, nf, nfe, nt);
    @(negedge clk);
    pc_write_ev = 1'b1; skip_true_ev = 1'b1; jump_ev = 1'b1;
    @(negedge clk);
    pc_write_ev = 1'b0; skip_true_ev = 1'b0; jump_ev = 1'b0;
    run_instr(1'b0, 1'b0, 1'b0, 1'b0, gap, nf, nfe, nt);
    chk("R7 mid-cycle event gap", gap, 4);
    chk("R7 mid-cycle event flush", nf, 0);

    // R10 + R7: held pc write across two instructions, long mode
    run_instr(1'b1, 1'b0, 1'b0, 1'b1, gap, nf, nfe, nt);
    chk("R10 first stretched gap", gap, 8);
    run_instr(1'b1, 1'b0, 1'b0, 1'b1, gap, nf, nfe, nt);
    chk("R10 second stretched gap", gap, 8);
    chk("R7 no chained extra cycle flush", nf, 4);
    pc_write_ev = 1'b0;

    // R10 in short mode with held skip
    do_reset(1'b0);
    run_instr(1'b0, 1'b0, 1'b1, 1'b1, gap, nf, nfe, nt);
    chk("R10 short first gap", gap, 4);
    run_instr(1'b0, 1'b0, 1'b1, 1'b1, gap, nf, nfe, nt);
    chk("R10 short second gap", gap, 4);
    skip_true_ev = 1'b0;

    // R9: option change outside reset ignored
    opt_long = 1'b1;
    run_instr(1'b0, 1'b0, 1'b0, 1'b0, gap, nf, nfe, nt);
    chk("R9 short mode kept gap", gap, 2);
    do_reset(1'b1);
    opt_long = 1'b0;
    run_instr(1'b0, 1'b0, 1'b0, 1'b0, gap, nf, nfe, nt);
    run_instr(1'b0, 1'b0, 1'b0, 1'b0, gap, nf, nfe, nt);
    chk("R9 long mode kept gap", gap, 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule